// File: doc/BRIEF.md
# Answer-to-Reset Timing Monitor

This block supervises the interval between powering a contact card and the first character the card sends back. After an activation-complete pulse it holds the card reset line low and counts card clock ticks. It watches the synchronised card data line for the falling edge that opens a start bit, and it judges each such edge by the tick count of the current phase. Edges that arrive too soon are disregarded, slightly later ones raise an early event, and edges inside the accepted window mark the card as answered and freeze counting so the host can take over the data line.

When the low-reset phase expires without an answer, the block drives reset high and opens a second phase with the same rules. When that phase also expires, it reports the card as mute. A warm-reset request pulls reset low for a fixed number of ticks, raises it again and restarts the high-reset phase. The end of that warm sequence, by an answer or by muteness, is signalled with a one-cycle pulse that lets the host clear its request bit. A deactivation pulse aborts everything at any time.

All limits are counted in card clock ticks, which arrive as a one-cycle enable on the system clock. Widths and limits are parameters. The defaults are a 16-bit counter, a 200-tick blind interval, a 352-tick early boundary, a 41950-tick phase limit and a 400-tick warm-reset low time.

Top module: `atr_monitor`

## Requirements
- R1: After synchronous reset, card_rst, answered, early_pulse, mute_pulse and warm_clr are all 0.
- R2: An act_done pulse while idle starts the low-reset phase: card_rst stays 0 and the phase count starts at 0. The count advances only on clock edges where card_clk_tick is 1.
- R3: The data line passes through a two-stage synchroniser. A falling edge first sampled low at clock edge B is judged against the count held after edge B+1, and its result appears after edge B+2. A judged count below IGNORE_LIM (20 in the bench) has no effect.
- R4: A judged count from IGNORE_LIM up to EARLY_LIM-1 produces a one-cycle early_pulse, and the phase continues unchanged.
- R5: A judged count from EARLY_LIM up to WAIT_LIM-1 sets answered and stops counting, with card_rst kept at its level. An answer judged in the same cycle as the phase expiry wins, and later edges have no effect.
- R6: When WAIT_LIM ticks pass in the low-reset phase without an answer, card_rst goes to 1 on that tick's edge. A new phase then starts from 0 with the same R3 to R5 rules.
- R7: When WAIT_LIM ticks pass in the high-reset phase without an answer, mute_pulse is 1 for one cycle, counting stops and card_rst stays 1.
- R8: warm_req in any phase or after an answer or mute clears answered and forces card_rst to 0. The block then ignores data-line edges for RST_LOW_LIM ticks (50 in the bench), after which card_rst goes to 1 and a high-reset phase begins. warm_req during that low time or while idle is ignored.
- R9: warm_clr pulses for one cycle together with the answer or the mute that ends a warm sequence, and never after a cold activation alone.
- R10: deact at any time returns the block to idle with card_rst 0 and answered 0 on the next edge. act_done outside idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| card_clk_tick | input | 1 | One-cycle enable marking a card clock period |
| act_done | input | 1 | Pulse: card power-up finished, start monitoring |
| deact | input | 1 | Pulse: card deactivation, abort monitoring |
| warm_req | input | 1 | Pulse: request a warm reset of the card |
| io_async | input | 1 | Card data line, asynchronous |
| card_rst | output | 1 | Level driven onto the card reset contact |
| early_pulse | output | 1 | One-cycle event: start bit arrived too early |
| mute_pulse | output | 1 | One-cycle event: card declared mute |
| warm_clr | output | 1 | One-cycle pulse ending a warm-reset sequence |
| answered | output | 1 | Card has answered inside the window |

## Verification
Data-line falls are placed at judged counts just below and at each boundary of the blind interval and the early band, and at the last count before expiry. This separates off-by-one errors in every comparison and shows the priority of an answer over a timeout. Phases run to expiry with no edge to show the reset-raise and mute timing, and one run pauses the tick input to show that only ticks count. Warm requests are issued from the mute state, the answered state and the middle of a cold phase. Each pattern separates the warm_clr cause from a cold-only mute, and the edge placed during the warm low time shows that such edges are ignored.

// File: rtl/atr_pkg.sv
package atr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLD,
        ST_WARM_LOW,
        ST_HIGH,
        ST_ANSWERED,
        ST_MUTE
    } atr_state_e;

    typedef enum logic [1:0] {
        ZONE_NONE,
        ZONE_IGNORE,
        ZONE_EARLY,
        ZONE_VALID
    } atr_zone_e;

    typedef struct packed {
        logic early;
        logic mute;
        logic warm_clr;
    } atr_evt_t;

    // Place a judged tick count into its answer zone.
    function automatic atr_zone_e judge_zone(input logic [31:0] cnt,
                                             input logic [31:0] blind_lim,
                                             input logic [31:0] early_lim);
        if (cnt < blind_lim)
            return ZONE_IGNORE;
        else if (cnt < early_lim)
            return ZONE_EARLY;
        else
            return ZONE_VALID;
    endfunction

    // States in which the tick counter advances.
    function automatic logic phase_counts(input atr_state_e s);
        return (s == ST_COLD) || (s == ST_WARM_LOW) || (s == ST_HIGH);
    endfunction

    // States in which data-line edges are judged.
    function automatic logic phase_listens(input atr_state_e s);
        return (s == ST_COLD) || (s == ST_HIGH);
    endfunction

    // States from which a warm request is honoured.
    function automatic logic warm_allowed(input atr_state_e s);
        return (s == ST_COLD) || (s == ST_HIGH) ||
               (s == ST_ANSWERED) || (s == ST_MUTE);
    endfunction

endpackage

// File: rtl/atr_io_sync.sv
module atr_io_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic io_in,
    output logic io_fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   prev_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b1;
                else     chain[0] <= io_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b1;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[LAST];
    end

    assign io_fall = prev_q & ~chain[LAST];

    // A detected fall lasts exactly one cycle
    p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
        io_fall |=> !io_fall);

endmodule

// File: rtl/atr_tick_counter.sv
module atr_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] term_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run && tick)
            cnt <= cnt + 1'b1;
    end

    assign hit = run && tick && (cnt == term_m1);

    // Without a tick or a restart the count is frozen
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> $stable(cnt));

endmodule

// File: rtl/atr_window_judge.sv
module atr_window_judge import atr_pkg::*; #(
    parameter int CNT_W      = 16,
    parameter int IGNORE_LIM = 200,
    parameter int EARLY_LIM  = 352
) (
    input  logic             listen,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt,
    output atr_zone_e        zone
);
    always_comb begin
        if (listen && fall)
            zone = judge_zone(32'(cnt), 32'(IGNORE_LIM), 32'(EARLY_LIM));
        else
            zone = ZONE_NONE;
    end

endmodule

// File: rtl/atr_seq_fsm.sv
module atr_seq_fsm import atr_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int WAIT_LIM    = 41950,
    parameter int RST_LOW_LIM = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_done,
    input  logic             deact,
    input  logic             warm_req,
    input  atr_zone_e        zone,
    input  logic             hit,
    output logic             cnt_clr,
    output logic             cnt_run,
    output logic [CNT_W-1:0] term_m1,
    output logic             listen,
    output logic             card_rst,
    output logic             answered,
    output atr_evt_t         evt
);
    localparam logic [CNT_W-1:0] WAIT_M1    = CNT_W'(WAIT_LIM - 1);
    localparam logic [CNT_W-1:0] RST_LOW_M1 = CNT_W'(RST_LOW_LIM - 1);

    atr_state_e st_q, st_d;
    logic       rst_q, rst_d;
    logic       ans_q, ans_d;
    logic       warm_q, warm_d;
    atr_evt_t   evt_q, evt_d;
    logic       go_warm;

    assign go_warm = warm_req && warm_allowed(st_q);

    always_comb begin
        st_d    = st_q;
        rst_d   = rst_q;
        ans_d   = ans_q;
        warm_d  = warm_q;
        evt_d   = '0;
        cnt_clr = 1'b0;
        if (deact) begin
            st_d    = ST_IDLE;
            rst_d   = 1'b0;
            ans_d   = 1'b0;
            warm_d  = 1'b0;
            cnt_clr = 1'b1;
        end else if (go_warm) begin
            st_d    = ST_WARM_LOW;
            rst_d   = 1'b0;
            ans_d   = 1'b0;
            warm_d  = 1'b1;
            cnt_clr = 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (act_done) begin
                        st_d    = ST_COLD;
                        rst_d   = 1'b0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_COLD, ST_HIGH: begin
                    if (zone == ZONE_EARLY) begin
                        evt_d.early = 1'b1;
                    end else if (zone == ZONE_VALID) begin
                        st_d           = ST_ANSWERED;
                        ans_d          = 1'b1;
                        evt_d.warm_clr = warm_q;
                        warm_d         = 1'b0;
                    end else if (hit) begin
                        if (st_q == ST_COLD) begin
                            st_d    = ST_HIGH;
                            rst_d   = 1'b1;
                            cnt_clr = 1'b1;
                        end else begin
                            st_d           = ST_MUTE;
                            evt_d.mute     = 1'b1;
                            evt_d.warm_clr = warm_q;
                            warm_d         = 1'b0;
                        end
                    end
                end
                ST_WARM_LOW: begin
                    if (hit) begin
                        st_d    = ST_HIGH;
                        rst_d   = 1'b1;
                        cnt_clr = 1'b1;
                    end
                end
                ST_ANSWERED, ST_MUTE: ;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            rst_q  <= 1'b0;
            ans_q  <= 1'b0;
            warm_q <= 1'b0;
            evt_q  <= '0;
        end else begin
            st_q   <= st_d;
            rst_q  <= rst_d;
            ans_q  <= ans_d;
            warm_q <= warm_d;
            evt_q  <= evt_d;
        end
    end

    assign cnt_run  = phase_counts(st_q);
    assign term_m1  = (st_q == ST_WARM_LOW) ? RST_LOW_M1 : WAIT_M1;
    assign listen   = phase_listens(st_q);
    assign card_rst = rst_q;
    assign answered = ans_q;
    assign evt      = evt_q;

    // R2: activation from idle opens the cold phase with reset low
    p_act_low_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && act_done && !deact) |=> (!card_rst && st_q == ST_COLD));

    // R4: an early event and a mute event never coincide
    p_early_mute_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.early && evt_q.mute));

    // R5: an answer holds until a warm request or deactivation
    p_answer_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (answered && !deact && !warm_req) |=> answered);

    // R6: reset rises only on entry to the high-reset phase
    p_rise_high_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(card_rst) |-> (st_q == ST_HIGH));

    // R7: mute is only declared with reset high
    p_mute_rst_high_r7: assert property (@(posedge clk) disable iff (rst)
        evt_q.mute |-> card_rst);

    // R8: during the warm low time the reset line is low
    p_warm_low_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WARM_LOW) |-> !card_rst);

    // R9: warm clear only accompanies an answer or a mute
    p_wclr_cause_r9: assert property (@(posedge clk) disable iff (rst)
        evt_q.warm_clr |-> (answered || evt_q.mute));

    // R10: deactivation lands in idle with reset low and no answer
    p_deact_idle_r10: assert property (@(posedge clk) disable iff (rst)
        deact |=> (st_q == ST_IDLE && !card_rst && !answered));

endmodule

// File: rtl/atr_monitor.sv
module atr_monitor import atr_pkg::*; #(
    parameter int CNT_W       = 16,
    parameter int IGNORE_LIM  = 200,
    parameter int EARLY_LIM   = 352,
    parameter int WAIT_LIM    = 41950,
    parameter int RST_LOW_LIM = 400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic card_clk_tick,
    input  logic act_done,
    input  logic deact,
    input  logic warm_req,
    input  logic io_async,
    output logic card_rst,
    output logic early_pulse,
    output logic mute_pulse,
    output logic warm_clr,
    output logic answered
);
    logic             io_fall;
    logic             cnt_clr;
    logic             cnt_run;
    logic [CNT_W-1:0] term_m1;
    logic [CNT_W-1:0] cnt;
    logic             hit;
    logic             listen;
    atr_zone_e        zone;
    atr_evt_t         evt;

    atr_io_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .io_in   (io_async),
        .io_fall (io_fall)
    );

    atr_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .run     (cnt_run),
        .tick    (card_clk_tick),
        .term_m1 (term_m1),
        .cnt     (cnt),
        .hit     (hit)
    );

    atr_window_judge #(
        .CNT_W      (CNT_W),
        .IGNORE_LIM (IGNORE_LIM),
        .EARLY_LIM  (EARLY_LIM)
    ) u_judge (
        .listen (listen),
        .fall   (io_fall),
        .cnt    (cnt),
        .zone   (zone)
    );

    atr_seq_fsm #(
        .CNT_W       (CNT_W),
        .WAIT_LIM    (WAIT_LIM),
        .RST_LOW_LIM (RST_LOW_LIM)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .act_done (act_done),
        .deact    (deact),
        .warm_req (warm_req),
        .zone     (zone),
        .hit      (hit),
        .cnt_clr  (cnt_clr),
        .cnt_run  (cnt_run),
        .term_m1  (term_m1),
        .listen   (listen),
        .card_rst (card_rst),
        .answered (answered),
        .evt      (evt)
    );

    assign early_pulse = evt.early;
    assign mute_pulse  = evt.mute;
    assign warm_clr    = evt.warm_clr;

endmodule

// File: tb/atr_monitor_test.sv
`timescale 1ns/1ps
module atr_monitor_test;

    localparam int IGN  = 20;
    localparam int ERL  = 35;
    localparam int WT   = 300;
    localparam int WLOW = 50;

    localparam int K_RST_UP = 0;
    localparam int K_RST_DN = 1;
    localparam int K_EARLY  = 2;
    localparam int K_MUTE   = 3;
    localparam int K_WCLR   = 4;
    localparam int K_ANS_UP = 5;
    localparam int K_ANS_DN = 6;

    typedef struct {
        int    kind;
        int    cyc;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic act_done = 1'b0;
    logic deact = 1'b0;
    logic warm_req = 1'b0;
    logic io = 1'b1;
    logic card_rst, early_pulse, mute_pulse, warm_clr, answered;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;
    logic prev_rst = 1'b0;
    logic prev_ans = 1'b0;
    exp_t q[$];

    atr_monitor #(
        .CNT_W       (16),
        .IGNORE_LIM  (IGN),
        .EARLY_LIM   (ERL),
        .WAIT_LIM    (WT),
        .RST_LOW_LIM (WLOW),
        .SYNC_STAGES (2)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .card_clk_tick (tick),
        .act_done      (act_done),
        .deact         (deact),
        .warm_req      (warm_req),
        .io_async      (io),
        .card_rst      (card_rst),
        .early_pulse   (early_pulse),
        .mute_pulse    (mute_pulse),
        .warm_clr      (warm_clr),
        .answered      (answered)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string kname(input int k);
        case (k)
            K_RST_UP: return "rst_up";
            K_RST_DN: return "rst_dn";
            K_EARLY:  return "early";
            K_MUTE:   return "mute";
            K_WCLR:   return "warm_clr";
            K_ANS_UP: return "ans_up";
            default:  return "ans_dn";
        endcase
    endfunction

    task automatic expect_evt(input int kind, input int at_cyc, input string req);
        exp_t e;
        e.kind = kind;
        e.cyc  = at_cyc;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic observe(input int kind);
        int idx;
        idx = -1;
        for (int i = 0; i < q.size(); i++) begin
            if (idx < 0 && q[i].kind == kind) idx = i;
        end
        checks++;
        if (idx < 0) begin
            errors++;
            $display("FAIL unexpected event %s at cycle %0d (actual event, expected none)",
                     kname(kind), cyc);
        end else begin
            if (q[idx].cyc != cyc) begin
                errors++;
                $display("FAIL %s: event %s at cycle %0d, expected cycle %0d",
                         q[idx].req, kname(kind), cyc, q[idx].cyc);
            end
            q.delete(idx);
        end
    endtask

    // Scoreboard monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (rst || !mon_on) begin
            prev_rst = card_rst;
            prev_ans = answered;
        end else begin
            if (card_rst && !prev_rst) observe(K_RST_UP);
            if (!card_rst && prev_rst) observe(K_RST_DN);
            if (early_pulse)           observe(K_EARLY);
            if (mute_pulse)            observe(K_MUTE);
            if (warm_clr)              observe(K_WCLR);
            if (answered && !prev_ans) observe(K_ANS_UP);
            if (!answered && prev_ans) observe(K_ANS_DN);
            prev_rst = card_rst;
            prev_ans = answered;
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d",
                     req, actual, expected, cyc);
        end
    endtask

    task automatic at(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_act(output int a);
        act_done = 1'b1;
        a = cyc + 1;
        @(negedge clk);
        act_done = 1'b0;
    endtask

    task automatic do_deact(output int d);
        deact = 1'b1;
        d = cyc + 1;
        @(negedge clk);
        deact = 1'b0;
    endtask

    task automatic do_warm(output int w);
        warm_req = 1'b1;
        w = cyc + 1;
        @(negedge clk);
        warm_req = 1'b0;
    endtask

    // Drop the data line for one cycle; judged count = j + 2 - phase start
    task automatic fall_at(input int j);
        at(j);
        io = 1'b0;
        @(negedge clk);
        io = 1'b1;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d (expected completion)", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int a, d, w, h;
        at(3);
        rst = 1'b0;
        at(5);
        // R1: quiet reset state
        chk("R1 card_rst", card_rst, 0);
        chk("R1 answered", answered, 0);
        chk("R1 pulses", {early_pulse, mute_pulse, warm_clr}, 0);
        mon_on = 1'b1;

        // Cold activation: ignored, early, then valid answer (R2 R3 R4 R5)
        do_act(a);
        fall_at(a + 8);                                   // count 10: R3 ignored
        fall_at(a + 23);                                  // count 25: R4 early
        expect_evt(K_EARLY, a + 26, "R4");
        fall_at(a + 98);                                  // count 100: R5 answer
        expect_evt(K_ANS_UP, a + 101, "R5");
        at(a + 400);
        chk("R5 card_rst held low", card_rst, 0);
        chk("R5 answered", answered, 1);
        fall_at(a + 410);                                 // R5 later edge no effect
        at(a + 420);
        chk("R5 answered after extra edge", answered, 1);

        // R10 deactivation clears the answer
        do_deact(d);
        expect_evt(K_ANS_DN, d, "R10");

        // Boundaries IGN-1 and ERL-1 (R3 R4)
        do_act(a);
        fall_at(a + 17);                                  // count 19: ignored
        fall_at(a + 32);                                  // count 34: early
        expect_evt(K_EARLY, a + 35, "R4");
        at(a + 60);
        chk("R3 no answer at blind edge", answered, 0);
        do_deact(d);

        // Boundaries IGN and ERL (R4 R5)
        do_act(a);
        fall_at(a + 18);                                  // count 20: early
        expect_evt(K_EARLY, a + 21, "R4");
        fall_at(a + 33);                                  // count 35: valid
        expect_evt(K_ANS_UP, a + 36, "R5");
        at(a + 50);
        do_deact(d);
        expect_evt(K_ANS_DN, d, "R10");

        // Answer at the last count beats expiry (R5)
        do_act(a);
        fall_at(a + 297);                                 // count 299
        expect_evt(K_ANS_UP, a + 300, "R5");
        at(a + 350);
        chk("R5 no reset raise at expiry tie", card_rst, 0);
        do_deact(d);
        expect_evt(K_ANS_DN, d, "R10");

        // Tick pause and ignored re-activation, then high phase (R2 R6 R10)
        do_act(a);
        at(a + 50);
        act_done = 1'b1;                                  // R10 ignored outside idle
        @(negedge clk);
        act_done = 1'b0;
        at(a + 100);
        tick = 1'b0;                                      // R2 100 ticks withheld
        at(a + 200);
        tick = 1'b1;
        h = a + WT + 100;
        expect_evt(K_RST_UP, h, "R6");
        fall_at(h + 8);                                   // count 10: ignored
        fall_at(h + 23);                                  // count 25: early
        expect_evt(K_EARLY, h + 26, "R6");
        fall_at(h + 148);                                 // count 150: answer
        expect_evt(K_ANS_UP, h + 151, "R6");
        at(h + 200);
        chk("R6 reset high after answer", card_rst, 1);
        do_deact(d);
        expect_evt(K_RST_DN, d, "R10");
        expect_evt(K_ANS_DN, d, "R10");
        at(d + 2);
        chk("R10 card_rst after deact", card_rst, 0);

        // Mute after cold activation, no warm clear (R7 R9)
        do_act(a);
        expect_evt(K_RST_UP, a + WT, "R6");
        expect_evt(K_MUTE, a + 2 * WT, "R7");
        at(a + 2 * WT + 40);
        chk("R7 reset stays high", card_rst, 1);
        chk("R7 no answer", answered, 0);

        // Warm from mute, edge during low ignored, then mute again (R8 R9)
        do_warm(w);
        expect_evt(K_RST_DN, w, "R8");
        fall_at(w + 10);                                  // ignored in warm low
        expect_evt(K_RST_UP, w + WLOW, "R8");
        expect_evt(K_MUTE, w + WLOW + WT, "R7");
        expect_evt(K_WCLR, w + WLOW + WT, "R9");
        at(w + WLOW + WT + 20);

        // Warm from mute, then answer (R8 R9)
        do_warm(w);
        expect_evt(K_RST_DN, w, "R8");
        h = w + WLOW;
        expect_evt(K_RST_UP, h, "R8");
        fall_at(h + 98);
        expect_evt(K_ANS_UP, h + 101, "R9");
        expect_evt(K_WCLR, h + 101, "R9");
        at(h + 130);
        chk("R9 answered after warm", answered, 1);

        // Warm from answered, then deact during low, warm in idle ignored (R8 R10)
        do_warm(w);
        expect_evt(K_RST_DN, w, "R8");
        expect_evt(K_ANS_DN, w, "R8");
        at(w + 20);
        do_deact(d);
        at(w + 200);
        do_warm(d);                                       // R8 ignored while idle
        at(w + 400);
        chk("R10 idle reset low", card_rst, 0);

        // Warm in the middle of a cold phase (R8 R9)
        do_act(a);
        at(a + 100);
        do_warm(w);
        expect_evt(K_RST_UP, w + WLOW, "R8");
        expect_evt(K_MUTE, w + WLOW + WT, "R7");
        expect_evt(K_WCLR, w + WLOW + WT, "R9");
        at(w + WLOW + WT + 30);

        // Every scheduled event must have been seen
        checks++;
        if (q.size() != 0) begin
            errors++;
            foreach (q[i])
                $display("FAIL %s: missing event %s, expected at cycle %0d (actual none)",
                         q[i].req, kname(q[i].kind), q[i].cyc);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule